// File: doc/BRIEF.md
# Codec frame timing controller

This block produces the frame-sync timing for a serial converter interface. It runs from the master clock. A counter marks out a sampling frame whose nominal length is a programmable number of master-clock cycles. Each frame opens with a one-cycle low pulse on the frame-sync output. The next sixteen cycles carry a full-duplex word. The host shifts its DAC word in on the data input, and the block shifts the ADC word out on the data output, most significant bit first. The serial bit clock equals the master clock. Output bits change on the rising edge. Input bits are captured on a rising edge while the matching bit cycle is shown.

The two lowest bits of each received primary word form a command. When those bits are zero, two command pins supply the command in their place. The command acts on the frame after the one that carried it, and only on that frame. It can lengthen or shorten that frame by a signed count taken from the adjustment input. It can also insert a second frame-sync pulse halfway through that frame, so the host can load a control word. After the affected frame, the period returns to its nominal value.

Top module: `codec_frame_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, fs_n_o is 1 and dout_o, dac_valid_o and ctrl_valid_o are 0. Reset discards a pending command, so the first frame after reset has the nominal length.
- R2: The frame length L is period_i clamped to the range [2*WORD_W+4, 2^CNT_W-1]. It is sampled on the edge that starts a frame. fs_n_o is low for exactly one cycle at the start of every frame, and the next frame starts L cycles later.
- R3: The adc_word_i value present on the frame-start edge is driven on dout_o MSB first, one bit per cycle, in frame cycles 1 to WORD_W. Frame cycle 0 is the sync cycle. Outside those cycles dout_o is 0.
- R4: din_i is captured on the edges that end frame cycles 1 to WORD_W, MSB first. In frame cycle WORD_W+1, dac_valid_o is 1 for one cycle and dac_word_o holds bits WORD_W-1 down to 2 of the word.
- R5: The command code is bits 1:0 of the received primary word when they are nonzero. Otherwise it is cmd_pins_i, sampled on the edge that completes the word. Codes: 00 none, 01 later, 10 earlier, 11 secondary.
- R6: Code 01 makes the following frame last clamp(period_i + adjust_i) cycles. adjust_i is two's complement, so a negative value shortens the frame.
- R7: Code 10 makes the following frame last clamp(period_i - adjust_i) cycles, so a negative adjust_i lengthens the frame.
- R8: A command affects only the frame that follows the one carrying it. When that frame carries code 00 and the pins read 00, the frame after it has the nominal length again.
- R9: Code 11 adds a second one-cycle low pulse on fs_n_o in the following frame, at frame cycle H = L>>1. The word on din_i in cycles H+1 to H+WORD_W appears on ctrl_word_o, with ctrl_valid_o high for one cycle in cycle H+WORD_W+1. The bits of that word have no effect on frame timing.
- R10: A lengthened or shortened frame is clamped to the range given in R2, for example a request below 2*WORD_W+4 yields 2*WORD_W+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Nominal frame length in master-clock cycles |
| adjust_i | input | ADJ_W | Signed frame-length adjustment |
| cmd_pins_i | input | 2 | Command used when the in-band bits are 00 |
| adc_word_i | input | WORD_W | Word to send in the next frame |
| din_i | input | 1 | Serial data from the host |
| fs_n_o | output | 1 | Active-low frame sync |
| dout_o | output | 1 | Serial data to the host |
| dac_word_o | output | WORD_W-2 | Received DAC bits |
| dac_valid_o | output | 1 | One-cycle strobe for dac_word_o |
| ctrl_word_o | output | WORD_W | Received secondary control word |
| ctrl_valid_o | output | 1 | One-cycle strobe for ctrl_word_o |

## Verification
The bench builds the block with CNT_W=8, ADJ_W=6 and WORD_W=16. With these values the 36-cycle lower clamp and the 255-cycle upper clamp can both be reached within a few hundred cycles. A 6-bit adjustment covers both signs and its extreme of 31. The frame sequence also covers an odd period, where the half point is rounded down, and a reset that arrives while a command is pending.

// File: rtl/codec_ft_pkg.sv
package codec_ft_pkg;
    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_LATER   = 2'b01,
        CMD_EARLIER = 2'b10,
        CMD_SECOND  = 2'b11
    } cmd_e;
endpackage

// File: rtl/codec_ft_cmd_sel.sv
module codec_ft_cmd_sel
    import codec_ft_pkg::*;
(
    input  logic [1:0] inband_i,
    input  logic [1:0] pins_i,
    output cmd_e       cmd_o
);
    // In-band code wins whenever it is nonzero; pins fill in otherwise.
    always_comb begin
        if (inband_i != 2'b00) cmd_o = cmd_e'(inband_i);
        else                   cmd_o = cmd_e'(pins_i);
    end
endmodule

// File: rtl/codec_ft_len_calc.sv
module codec_ft_len_calc
    import codec_ft_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int ADJ_W   = 10,
    parameter int MIN_LEN = 36
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic [ADJ_W-1:0] adjust_i,
    input  cmd_e             cmd_i,
    output logic [CNT_W-1:0] nominal_o,
    output logic [CNT_W-1:0] len_o
);
    localparam int SW = ((CNT_W > ADJ_W) ? CNT_W : ADJ_W) + 2;
    localparam logic signed [SW-1:0] LO_S = SW'(MIN_LEN);
    localparam logic signed [SW-1:0] HI_S = SW'((64'd1 << CNT_W) - 64'd1);

    function automatic logic [CNT_W-1:0] fit(input logic signed [SW-1:0] v);
        logic signed [SW-1:0] r;
        if (v < LO_S)      r = LO_S;
        else if (v > HI_S) r = HI_S;
        else               r = v;
        return r[CNT_W-1:0];
    endfunction

    logic signed [SW-1:0] per_s;
    logic signed [SW-1:0] adj_s;
    logic signed [SW-1:0] raw_s;

    always_comb begin
        per_s = $signed({{(SW-CNT_W){1'b0}}, period_i});
        adj_s = $signed({{(SW-ADJ_W){adjust_i[ADJ_W-1]}}, adjust_i});
        case (cmd_i)
            CMD_LATER:   raw_s = per_s + adj_s;
            CMD_EARLIER: raw_s = per_s - adj_s;
            default:     raw_s = per_s;
        endcase
        nominal_o = fit(per_s);
        len_o     = fit(raw_s);
    end
endmodule

// File: rtl/codec_frame_ctrl.sv
module codec_frame_ctrl
    import codec_ft_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADJ_W  = 10,
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [ADJ_W-1:0]  adjust_i,
    input  logic [1:0]        cmd_pins_i,
    input  logic [WORD_W-1:0] adc_word_i,
    input  logic              din_i,
    output logic              fs_n_o,
    output logic              dout_o,
    output logic [WORD_W-3:0] dac_word_o,
    output logic              dac_valid_o,
    output logic [WORD_W-1:0] ctrl_word_o,
    output logic              ctrl_valid_o
);
    localparam int MIN_LEN = 2 * WORD_W + 4;
    localparam int XW      = CNT_W + 1;
    localparam logic [XW-1:0] ONE_X  = XW'(1);
    localparam logic [XW-1:0] WORD_X = XW'(WORD_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  half;
        cmd_e              pend;
        cmd_e              act;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-3:0] dac;
        logic              dac_vld;
        logic [WORD_W-1:0] ctl;
        logic              ctl_vld;
    } state_t;

    state_t q, d;

    logic [WORD_W-1:0] rx_full;
    cmd_e              cmd_new;
    logic [CNT_W-1:0]  nominal_len;
    logic [CNT_W-1:0]  next_len;
    logic [XW-1:0]     cnt_x, half_x;
    logic              in_pri, in_sec, pri_done, sec_done, frame_end;

    assign rx_full = {q.rx[WORD_W-2:0], din_i};

    codec_ft_cmd_sel u_sel (
        .inband_i (rx_full[1:0]),
        .pins_i   (cmd_pins_i),
        .cmd_o    (cmd_new)
    );

    codec_ft_len_calc #(
        .CNT_W   (CNT_W),
        .ADJ_W   (ADJ_W),
        .MIN_LEN (MIN_LEN)
    ) u_len (
        .period_i  (period_i),
        .adjust_i  (adjust_i),
        .cmd_i     (q.pend),
        .nominal_o (nominal_len),
        .len_o     (next_len)
    );

    always_comb begin
        cnt_x     = {1'b0, q.cnt};
        half_x    = {1'b0, q.half};
        in_pri    = (cnt_x >= ONE_X) && (cnt_x <= WORD_X);
        in_sec    = (q.act == CMD_SECOND) && (cnt_x >= half_x + ONE_X)
                    && (cnt_x <= half_x + WORD_X);
        pri_done  = (cnt_x == WORD_X);
        sec_done  = (q.act == CMD_SECOND) && (cnt_x == half_x + WORD_X);
        frame_end = (q.cnt == q.len - CNT_W'(1));
    end

    always_comb begin
        d         = q;
        d.dac_vld = 1'b0;
        d.ctl_vld = 1'b0;
        if (in_pri || in_sec) d.rx = rx_full;
        if (in_pri)           d.tx = {q.tx[WORD_W-2:0], 1'b0};
        if (pri_done) begin
            d.dac     = rx_full[WORD_W-1:2];
            d.dac_vld = 1'b1;
            d.pend    = cmd_new;
        end
        if (sec_done) begin
            d.ctl     = rx_full;
            d.ctl_vld = 1'b1;
        end
        if (frame_end) begin
            d.cnt  = '0;
            d.len  = next_len;
            d.half = nominal_len >> 1;
            d.act  = q.pend;
            d.pend = CMD_NONE;
            d.tx   = adc_word_i;
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q         <= '0;
            q.len     <= nominal_len;
            q.cnt     <= nominal_len - CNT_W'(1);
            q.half    <= nominal_len >> 1;
            q.pend    <= CMD_NONE;
            q.act     <= CMD_NONE;
        end else begin
            q <= d;
        end
    end

    assign fs_n_o       = !((q.cnt == '0) || ((q.act == CMD_SECOND) && (q.cnt == q.half)));
    assign dout_o       = in_pri ? q.tx[WORD_W-1] : 1'b0;
    assign dac_word_o   = q.dac;
    assign dac_valid_o  = q.dac_vld;
    assign ctrl_word_o  = q.ctl;
    assign ctrl_valid_o = q.ctl_vld;
endmodule

// File: rtl/codec_ft_checks.sv
module codec_ft_checks (
    input logic clk_i,
    input logic rst_i,
    input logic fs_n_o,
    input logic dout_o,
    input logic dac_valid_o,
    input logic ctrl_valid_o
);
    // R1: cycle after a reset edge shows the idle state
    a_r1_reset_idle: assert property (@(posedge clk_i)
        rst_i |=> (fs_n_o && !dout_o && !dac_valid_o && !ctrl_valid_o));

    // R2: sync pulses are single cycles
    a_r2_single_sync: assert property (@(posedge clk_i) disable iff (rst_i)
        !fs_n_o |=> fs_n_o);

    // R3: no data is driven during a sync cycle
    a_r3_quiet_sync: assert property (@(posedge clk_i) disable iff (rst_i)
        !fs_n_o |-> !dout_o);

    // R4: DAC strobe is one cycle wide and never on a sync cycle
    a_r4_dac_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        dac_valid_o |=> !dac_valid_o);
    a_r4_dac_not_sync: assert property (@(posedge clk_i) disable iff (rst_i)
        dac_valid_o |-> fs_n_o);

    // R9: control strobe is one cycle wide and apart from the DAC strobe
    a_r9_ctrl_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_valid_o |=> !ctrl_valid_o);
    a_r9_ctrl_apart: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({ctrl_valid_o, dac_valid_o}) <= 1);
endmodule

bind codec_frame_ctrl codec_ft_checks u_checks (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .fs_n_o       (fs_n_o),
    .dout_o       (dout_o),
    .dac_valid_o  (dac_valid_o),
    .ctrl_valid_o (ctrl_valid_o)
);

// File: tb/codec_frame_ctrl_bench.sv
module codec_frame_ctrl_bench;
    localparam int CNT_W  = 8;
    localparam int ADJ_W  = 6;
    localparam int WORD_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  period;
    logic [ADJ_W-1:0]  adjust;
    logic [1:0]        pins;
    logic [WORD_W-1:0] adc;
    logic              din;
    logic              fs_n, dout, dac_vld, ctl_vld;
    logic [WORD_W-3:0] dac_word;
    logic [WORD_W-1:0] ctl_word;

    always #2.5 clk = ~clk;

    codec_frame_ctrl #(.CNT_W(CNT_W), .ADJ_W(ADJ_W), .WORD_W(WORD_W)) u_codec_frame_ctrl (
        .clk_i(clk), .rst_i(rst), .period_i(period), .adjust_i(adjust),
        .cmd_pins_i(pins), .adc_word_i(adc), .din_i(din), .fs_n_o(fs_n),
        .dout_o(dout), .dac_word_o(dac_word), .dac_valid_o(dac_vld),
        .ctrl_word_o(ctl_word), .ctrl_valid_o(ctl_vld)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic int clampi(input int v);
        if (v < 36)  return 36;
        if (v > 255) return 255;
        return v;
    endfunction

    // model state
    int cyc = 0, fstart = 0, flen = 50, fhalf = 25, pos = 0, fidx = -1, hold = 4;
    int p_cur = 50, a_cur = 0;
    int p_nx = 50, a_nx = 0;
    logic [1:0] pins_nx = 2'b00;
    logic [1:0] pend = 2'b00, act = 2'b00;
    logic sec_on = 1'b0;
    logic [15:0] pword = 16'h0, sword = 16'h0, adc_lat = 16'h0, adc_nx = 16'h0;

    // per-frame program: command bits, pins, adjust, period for frame f
    task automatic plan_frame(input int f);
        logic [1:0] cb;
        cb = 2'b00; pins_nx = 2'b00; a_nx = 0; p_nx = 50;
        case (f)
            1:  begin cb = 2'b01; a_nx = 5;   end           // R6 -> 55
            3:  begin cb = 2'b10; a_nx = 7;   end           // R7 -> 43
            4:  begin cb = 2'b01; a_nx = -6;  end           // R6 negative -> 44
            5:  begin cb = 2'b10; a_nx = -9;  end           // R7 negative -> 59
            6:  begin pins_nx = 2'b01; a_nx = 3; end        // R5 pins -> 53
            7:  begin pins_nx = 2'b10; a_nx = 4; end        // R5 pins -> 46
            8:  begin cb = 2'b10; pins_nx = 2'b01; a_nx = 2; end // R5 in-band wins -> 48
            9:  begin cb = 2'b11; end                       // R9 secondary
            10: begin pins_nx = 2'b11; end                  // R9 via pins
            11: begin cb = 2'b10; a_nx = 30; end            // R10 low clamp
            12: begin cb = 2'b01; a_nx = 31; p_nx = 240; end // R10 high clamp
            13: begin cb = 2'b11; p_nx = 36; end            // R9 at minimum length
            14: begin p_nx = 60; end
            15: begin cb = 2'b01; a_nx = 9; p_nx = 60; end  // R1 pending dropped by reset
            17: begin cb = 2'b11; p_nx = 51; end            // R9 odd period
            default: ;
        endcase
        pword   = {14'(16'h2C5B ^ (f * 16'h1357)), cb};
        sword   = 16'hA3C0 ^ 16'(f * 16'h0F1D);
        sword[1:0] = (f % 2 == 0) ? 2'b01 : 2'b10;          // R9 ignored bits
        adc_nx  = 16'h9E37 ^ 16'(f * 16'h2417);
    endtask

    task automatic model_wrap();
        act    = pend;
        pend   = 2'b00;
        if (act == 2'b01)      flen = clampi(p_cur + a_cur);
        else if (act == 2'b10) flen = clampi(p_cur - a_cur);
        else                   flen = clampi(p_cur);
        fhalf  = clampi(p_cur) / 2;
        sec_on = (act == 2'b11);
        adc_lat = adc;
        fstart = cyc + 1;
        fidx++;
        plan_frame(fidx);
    endtask

    initial begin
        period = 8'd50; adjust = '0; pins = 2'b00; adc = 16'h0; din = 1'b0;
    end

    always @(negedge clk) begin
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<20000", cyc);
            finish_run();
        end
        if (rst) begin
            chk("R1 fs idle in reset", fs_n, 1);
            chk("R1 dout idle in reset", dout, 0);
            chk("R1 dac strobe idle", dac_vld, 0);
            chk("R1 ctrl strobe idle", ctl_vld, 0);
            if (hold == 0) begin
                rst  = 1'b0;
                pend = 2'b00; act = 2'b00; sec_on = 1'b0;
                flen = clampi(p_cur);
                fstart = cyc - (flen - 1);
            end else hold--;
        end
        if (!rst) begin
            pos = cyc - fstart;
            chk("R2/R9 frame sync", fs_n,
                !((pos == 0) || (sec_on && pos == fhalf)));
            chk("R3 serial out", dout,
                (pos >= 1 && pos <= 16) ? adc_lat[16-pos] : 1'b0);
            chk("R4 dac strobe", dac_vld, pos == 17);
            if (pos == 17) chk("R4 dac word", dac_word, pword[15:2]);
            chk("R9 ctrl strobe", ctl_vld, sec_on && pos == fhalf + 17);
            if (sec_on && pos == fhalf + 17) chk("R9 ctrl word", ctl_word, sword);
            // drive serial input for this cycle
            if (pos >= 1 && pos <= 16)                         din = pword[16-pos];
            else if (sec_on && pos > fhalf && pos <= fhalf + 16) din = sword[16+fhalf-pos];
            else                                               din = cyc[0];
            if (pos == 3) begin
                p_cur = p_nx; a_cur = a_nx; pins = pins_nx; adc = adc_nx;
                period = 8'(p_nx); adjust = 6'(a_nx);
            end
            if (pos == 16) pend = (pword[1:0] != 2'b00) ? pword[1:0] : pins; // R5
            if (fidx == 15 && pos == 20) begin                                // R1 mid-run
                rst = 1'b1; hold = 2;
            end else if (pos == flen - 1) begin
                if (fidx == 19) finish_run();
                model_wrap();  // R8: length recomputed each frame from one command
            end
        end
        cyc++;
    end
endmodule